// File: doc/BRIEF.md
# Bus Master Burst Tenure Timer

This block sits beside a bus initiator and bounds how long that initiator may keep bursting once the central arbiter wants the bus for someone else. When the initiator starts a transaction (frame-start pulse), the timer captures an 8-bit tenure count and then counts it down by one on every following clock, stopping at zero. A count that has run out does not by itself end the burst. The block asks the initiator to stop only when the count is exhausted and the initiator's grant has also been taken away. While the grant stays asserted, the initiator may continue as long as it likes.

The tenure count comes from the `load_val` port by default. A parameter can instead fix it at a constant. The terminate request stays asserted until the initiator reports that its transaction is no longer active. The timer then goes back to idle and waits for the next frame-start.

The controller is a four-state machine:
- IDLE: waiting for a frame-start.
- COUNT: the tenure is running.
- EXPIRED: the tenure has run out and the block is waiting for the grant to drop.
- TERM: the terminate request is asserted.

Its transitions are:
- IDLE→COUNT: frame-start with a non-zero count.
- IDLE→EXPIRED: frame-start with a zero count.
- COUNT→EXPIRED: the count steps from one to zero.
- EXPIRED→TERM: the count is zero and the grant is low.
- COUNT/EXPIRED/TERM→IDLE: the active input is low.

Top module: `lat_timer`

## Requirements
- R1: After reset, and whenever reset is asserted mid-transaction, `terminate_req` is 0 on the next clock and the timer is idle.
- R2: A frame-start sampled while idle loads the count N. With `xact_active` high and `grant` low throughout, `terminate_req` is 0 after load edges +1 … +N and rises after load edge +N+1.
- R3: While `grant` is high, `terminate_req` never rises, however long ago the count ran out. Once `grant` is sampled low with the count at zero, `terminate_req` is 1 after that edge.
- R4: The count saturates at zero and never wraps, however many clocks elapse in the expired state.
- R5: Once asserted, `terminate_req` stays 1 while `xact_active` is high. It is 0 after the first edge at which `xact_active` is sampled low.
- R6: `xact_active` sampled low in any busy state returns the timer to idle without a terminate request. A later frame-start starts a fresh count.
- R7: A frame-start while the timer is not idle is ignored: the count is neither reloaded nor restarted.
- R8: A load value of zero makes the timer expire at once. With `grant` low, `terminate_req` is 1 after the edge following the load edge.
- R9: Dropping `grant` before the count runs out has no effect if `grant` is restored before expiry. Only the grant level seen at or after expiry matters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_val | input | 8 | Programmable tenure count |
| frame_start | input | 1 | Pulse when the initiator begins a transaction |
| grant | input | 1 | Initiator's bus grant, active high |
| xact_active | input | 1 | High while the initiator's transaction is in progress |
| terminate_req | output | 1 | Request to end the burst and re-arbitrate |

## Verification
The bench aims at the exact cycle of expiry. A design that is off by one edge would terminate before the guaranteed tenure, or one clock late. A long stretch in the expired state with the grant held is followed by a grant drop; a counter that wraps would miss the terminate at that point. Zero load values, a second frame-start in mid-burst and an early drop of the active input are also driven; wrong handling would show up as an early terminate, a restarted count, or a request that lingers after the transaction ended. A reference model compares `terminate_req` with its own value on every clock.

// File: rtl/lat_timer_pkg.sv
package lat_timer_pkg;
    typedef enum logic [1:0] {
        LT_IDLE    = 2'd0,
        LT_COUNT   = 2'd1,
        LT_EXPIRED = 2'd2,
        LT_TERM    = 2'd3
    } lt_state_e;
endpackage

// File: rtl/lat_timer_cnt.sv
module lat_timer_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec_en,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero,
    output logic             cnt_one
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_en) begin
            cnt <= load_val;
        end else if (dec_en && (cnt != '0)) begin
            cnt <= cnt - ONE;
        end
    end

    assign cnt_zero = (cnt == '0);
    assign cnt_one  = (cnt == ONE);
endmodule

// File: rtl/lat_timer_fsm.sv
module lat_timer_fsm
    import lat_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_start,
    input  logic      grant,
    input  logic      xact_active,
    input  logic      load_is_zero,
    input  logic      cnt_zero,
    input  logic      cnt_one,
    output logic      load_en,
    output logic      dec_en,
    output logic      terminate_req,
    output lt_state_e state
);
    lt_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            LT_IDLE: begin
                if (frame_start) begin
                    state_nx = load_is_zero ? LT_EXPIRED : LT_COUNT;
                end
            end
            LT_COUNT: begin
                if (!xact_active) begin
                    state_nx = LT_IDLE;
                end else if (cnt_one) begin
                    state_nx = LT_EXPIRED;
                end
            end
            LT_EXPIRED: begin
                if (!xact_active) begin
                    state_nx = LT_IDLE;
                end else if (cnt_zero && !grant) begin
                    state_nx = LT_TERM;
                end
            end
            LT_TERM: begin
                if (!xact_active) begin
                    state_nx = LT_IDLE;
                end
            end
            default: state_nx = LT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LT_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            terminate_req <= 1'b0;
        end else begin
            terminate_req <= (state_nx == LT_TERM);
        end
    end

    assign load_en = (state == LT_IDLE) && frame_start;
    assign dec_en  = (state != LT_IDLE);
endmodule

// File: rtl/lat_timer.sv
module lat_timer #(
    parameter int          CNT_W     = 8,
    parameter bit          USE_FIXED = 1'b0,
    parameter logic [CNT_W-1:0] FIXED_VAL = 8'd32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load_val,
    input  logic             frame_start,
    input  logic             grant,
    input  logic             xact_active,
    output logic             terminate_req
);
    import lat_timer_pkg::*;

    logic [CNT_W-1:0] src_val;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;
    logic             cnt_one;
    logic             load_en;
    logic             dec_en;
    lt_state_e        state;

    generate
        if (USE_FIXED) begin : g_fixed
            assign src_val = FIXED_VAL;
        end else begin : g_prog
            assign src_val = load_val;
        end
    endgenerate

    lat_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (src_val),
        .dec_en   (dec_en),
        .cnt      (cnt),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one)
    );

    lat_timer_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .grant         (grant),
        .xact_active   (xact_active),
        .load_is_zero  (src_val == '0),
        .cnt_zero      (cnt_zero),
        .cnt_one       (cnt_one),
        .load_en       (load_en),
        .dec_en        (dec_en),
        .terminate_req (terminate_req),
        .state         (state)
    );
endmodule

// File: rtl/lat_timer_chk.sv
module lat_timer_chk
    import lat_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             grant,
    input logic             xact_active,
    input logic             terminate_req,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] src_val,
    input lt_state_e        state
);
    AST_TERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (terminate_req && xact_active) |=> terminate_req); // R5

    AST_TERM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !xact_active |=> !terminate_req); // R6

    AST_GRANT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !terminate_req) |=> !terminate_req); // R3

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != LT_IDLE) && xact_active && (cnt == '0)) |=> (cnt == '0)); // R4

    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == LT_IDLE) && frame_start) |=> (cnt == $past(src_val))); // R2

    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != LT_IDLE) && xact_active && (cnt != '0)) |=> (cnt == $past(cnt) - 1'b1)); // R7

    AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == LT_IDLE) && frame_start && (src_val == '0)) |=> (state == LT_EXPIRED)); // R8
endmodule

bind lat_timer lat_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .grant         (grant),
    .xact_active   (xact_active),
    .terminate_req (terminate_req),
    .cnt           (cnt),
    .src_val       (src_val),
    .state         (state)
);

// File: tb/lat_timer_tb_top.sv
module lat_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] load_val = '0;
    logic       frame_start = 1'b0;
    logic       grant = 1'b0;
    logic       xact_active = 1'b0;
    logic       terminate_req;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference
    bit     m_busy = 1'b0;
    bit     m_term = 1'b0;
    integer m_left = 0;

    always #10 clk = ~clk;

    lat_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_val      (load_val),
        .frame_start   (frame_start),
        .grant         (grant),
        .xact_active   (xact_active),
        .terminate_req (terminate_req)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_term = 1'b0; m_left = 0;
        end else if (!m_busy) begin
            if (frame_start) begin
                m_busy = 1'b1; m_left = int'(load_val);
            end
        end else if (!xact_active) begin
            m_busy = 1'b0; m_term = 1'b0;
        end else if (!m_term) begin
            if (m_left > 0) m_left = m_left - 1;
            else if (!grant) m_term = 1'b1;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (terminate_req !== m_term) begin
            failures++;
            $display("FAIL %s model compare: terminate_req=%0b expected=%0b", cur_req, terminate_req, m_term);
        end
    endtask

    task automatic expect_term(bit exp, string req);
        checks++;
        if (terminate_req !== exp) begin
            failures++;
            $display("FAIL %s directed: terminate_req=%0b expected=%0b", req, terminate_req, exp);
        end
    endtask

    task automatic start(logic [7:0] n, bit g);
        load_val = n; grant = g; xact_active = 1'b1; frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
    endtask

    task automatic finish_xact();
        xact_active = 1'b0;
        tick();
    endtask

    initial begin
        @(negedge clk);
        repeat (3) tick();
        expect_term(1'b0, "R1");
        rst_n = 1'b1;

        cur_req = "R2";
        start(8'd5, 1'b0);
        for (int i = 1; i <= 5; i++) begin
            tick();
            expect_term(1'b0, "R2");
        end
        tick();
        expect_term(1'b1, "R2");

        cur_req = "R5";
        for (int i = 0; i < 3; i++) begin
            tick();
            expect_term(1'b1, "R5");
        end
        finish_xact();
        expect_term(1'b0, "R5");

        cur_req = "R3";
        start(8'd2, 1'b1);
        for (int i = 0; i < 8; i++) begin
            tick();
            expect_term(1'b0, "R3");
        end
        grant = 1'b0;
        tick();
        expect_term(1'b1, "R3");
        finish_xact();

        cur_req = "R4";
        start(8'd1, 1'b1);
        repeat (300) tick();
        grant = 1'b0;
        tick();
        expect_term(1'b1, "R4");
        finish_xact();

        cur_req = "R8";
        start(8'd0, 1'b0);
        expect_term(1'b0, "R8");
        tick();
        expect_term(1'b1, "R8");
        finish_xact();

        cur_req = "R9";
        start(8'd3, 1'b0);
        tick();
        tick();
        grant = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            expect_term(1'b0, "R9");
        end
        grant = 1'b0;
        tick();
        expect_term(1'b1, "R9");
        finish_xact();

        cur_req = "R6";
        start(8'd10, 1'b0);
        repeat (3) tick();
        finish_xact();
        expect_term(1'b0, "R6");
        repeat (12) tick();
        expect_term(1'b0, "R6");
        start(8'd1, 1'b0);
        tick();
        expect_term(1'b0, "R6");
        tick();
        expect_term(1'b1, "R6");
        finish_xact();

        cur_req = "R7";
        start(8'd3, 1'b0);
        tick();
        load_val = 8'd200; frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        tick();
        expect_term(1'b0, "R7");
        tick();
        expect_term(1'b1, "R7");

        cur_req = "R1";
        rst_n = 1'b0;
        tick();
        expect_term(1'b0, "R1");
        rst_n = 1'b1;
        xact_active = 1'b0;
        repeat (2) tick();
        expect_term(1'b0, "R1");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete, got=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule